// File: doc/BRIEF.md
# Codirectional 64 kbit/s Receiver with Octet Alignment

This block sits behind a line slicer on the receive side of a 64 kbit/s codirectional link. It takes the sliced signal as two active-low rails, one per pulse polarity, together with a 128 kHz sampling strobe from a separate clock recovery block. It decodes one data bit per pair of samples. It finds octet boundaries from bipolar violations, which are two consecutive marked blocks of the same polarity. It then fills two octet registers in turn. The octet that was completed most recently is sent out as an eight-bit burst, one bit per local 2.048 MHz clock, during a time slot chosen from two slot envelopes.

The local clock and the line rate are independent. Slips are therefore taken as whole octets: an octet is sent again when no new octet has arrived, and the older of two fresh octets is dropped when the local side runs slow. When violations stop arriving, the octet counter keeps running from the last violation received. A supervision input then chooses between two behaviours: keep sending the data, or blank the output to all ones while the expected violation is missing. An alarm is raised after a run of consecutive missed violations.

The whole block runs on the local 2.048 MHz clock. The 128 kHz recovered timing arrives as a one-cycle strobe with a half-bit phase flag.

Top module: `codir_rx_top`

## Requirements
- R1: On a strobe with sampleHalf=1 (the third unit interval of the bit), the decoded bit is 0 when either rail is low and 1 when both rails are high.
- R2: On a strobe with sampleHalf=0, exactly one low rail marks a block: railPosN low means positive, railNegN low means negative. A marked block with the same polarity as the previous marked block is a violation, and it makes the current bit the last bit of an octet.
- R3: Bits fill the octet register by position, with position 0 received first. At the first clock edge of the selected slot, the newest completed octet is chosen, and pcmOut carries positions 0..7 after that edge and the seven following edges, one position per edge.
- R4: slotPick=1 selects slotA and slotPick=0 selects slotB. After any edge at which the selected slot is low, pcmOut is 1, whatever the unselected slot does.
- R5: If no octet has completed since the previous slot, the same octet is sent again. If two or more have completed, only the newest is sent.
- R6: Without violations, octets still end every eighth bit after the last one, and the data stays correct while flywheelKeep=1.
- R7: A violation at any bit position other than the expected last position ends the octet at that bit and restarts the counting from there.
- R8: After the expected last bit of an octet arrives without a violation, and while flywheelKeep=0, slot output is all ones. This holds until a violation arrives at the expected position.
- R9: octetAlarm goes high at the eighth consecutive expected position without a violation, and it clears at the first violation found at the expected position.
- R10: forceOnes=1 makes pcmOut 1 after every edge.
- R11: During and directly after reset, pcmOut is 1 and octetAlarm is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local 2.048 MHz clock |
| rstN | input | 1 | Active-low synchronous reset |
| railPosN | input | 1 | Positive pulse rail, active low |
| railNegN | input | 1 | Negative pulse rail, active low |
| sampleStb | input | 1 | One-cycle 128 kHz sampling strobe |
| sampleHalf | input | 1 | Strobe phase: 0 = first unit interval, 1 = third unit interval |
| slotA | input | 1 | First time-slot envelope |
| slotB | input | 1 | Second time-slot envelope |
| slotPick | input | 1 | 1 selects slotA, 0 selects slotB |
| flywheelKeep | input | 1 | 1 keeps data valid without violations, 0 blanks on a missed violation |
| forceOnes | input | 1 | Forces the output to all ones |
| pcmOut | output | 1 | Serial burst output |
| octetAlarm | output | 1 | Loss-of-violation alarm |

## Verification
The bench runs a local frame that is shorter, and then longer, than the line octet period. This forces both repeats and drops; a design that read a half-filled register, or always alternated between the two registers, would send torn or stale octets. It inserts three stray bits to force a realignment. A design that ignored off-position violations would stay shifted and send rotated bytes from then on. It stops violations long enough to cross the alarm threshold, then resumes them. An off-by-one miss counter raises the alarm one octet early or late, and a design without a flywheel would lose the data. Blanking and slot selection are also checked with the unselected envelope active, so a design that listened to the wrong envelope would drive data in the idle gaps.

// File: rtl/codir_rx_pkg.sv
package codir_rx_pkg;
  parameter int unsigned OCTET_W = 8;
  localparam int unsigned IDX_W = $clog2(OCTET_W);

  // strobes from the line-side control to the octet datapath
  typedef struct packed {
    logic             wrEn;      // a decoded bit is ready
    logic             wrBit;     // its value
    logic [IDX_W-1:0] wrIdx;     // its position within the octet
    logic             commit;    // this bit closes the octet
    logic             blankHold; // blank slot output (lock lost, supervision on)
  } rxStrobe_t;
endpackage

// File: rtl/codir_rx_ctrl.sv
module codir_rx_ctrl
  import codir_rx_pkg::*;
#(
  parameter int unsigned MISS_LIMIT = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       railPosN,
  input  logic       railNegN,
  input  logic       sampleStb,
  input  logic       sampleHalf,
  input  logic       flywheelKeep,
  output rxStrobe_t  stb,
  output logic       octetAlarm
);
  localparam int unsigned MISS_W = $clog2(MISS_LIMIT + 1);
  localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(OCTET_W - 1);
  localparam logic [MISS_W-1:0] MISS_MAX = MISS_W'(MISS_LIMIT);

  logic             prevPol;
  logic             havePrev;
  logic             curViol;
  logic             lockLost;
  logic             alarmQ;
  logic [IDX_W-1:0] bitCnt;
  logic [MISS_W-1:0] missCnt;

  logic singleMark, markPol, anyMark, headStb, dataStb, atLast, octetEnd;

  always_comb begin
    singleMark = railPosN ^ railNegN;
    markPol    = ~railPosN;
    anyMark    = ~(railPosN & railNegN);
    headStb    = sampleStb & ~sampleHalf;
    dataStb    = sampleStb & sampleHalf;
    atLast     = (bitCnt == LAST_POS);
    octetEnd   = curViol | atLast;
  end

  // R2: block polarity and violation detection on the first-interval sample
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevPol  <= 1'b0;
      havePrev <= 1'b0;
      curViol  <= 1'b0;
    end else if (headStb) begin
      if (singleMark) begin
        curViol  <= havePrev && (markPol == prevPol);
        prevPol  <= markPol;
        havePrev <= 1'b1;
      end else begin
        curViol  <= 1'b0;
      end
    end
  end

  // R6, R7: octet position counter with flywheel and realignment
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (dataStb) begin
      bitCnt <= octetEnd ? '0 : bitCnt + 1'b1;
    end
  end

  // R8, R9: supervision of the expected violation
  always_ff @(posedge clk) begin
    if (!rstN) begin
      missCnt  <= '0;
      lockLost <= 1'b0;
      alarmQ   <= 1'b0;
    end else if (dataStb && atLast) begin
      if (curViol) begin
        missCnt  <= '0;
        lockLost <= 1'b0;
        alarmQ   <= 1'b0;
      end else begin
        lockLost <= 1'b1;
        if (missCnt != MISS_MAX) missCnt <= missCnt + 1'b1;
        if (int'(missCnt) >= int'(MISS_LIMIT) - 1) alarmQ <= 1'b1;
      end
    end
  end

  always_comb begin
    stb.wrEn      = dataStb;
    stb.wrBit     = ~anyMark;
    stb.wrIdx     = bitCnt;
    stb.commit    = dataStb & octetEnd;
    stb.blankHold = lockLost & ~flywheelKeep;
    octetAlarm    = alarmQ;
  end

  // R9: the alarm never stands while lock is held
  a_r9_alarm_needs_loss: assert property (@(posedge clk) disable iff (!rstN)
    alarmQ |-> lockLost);

  // R9: the alarm only rises on a data-sample strobe
  a_r9_alarm_at_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alarmQ) |-> $past(sampleStb && sampleHalf));

  // R6: the position counter only moves on data samples
  a_r6_count_on_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(sampleStb && sampleHalf) |=> $stable(bitCnt));
endmodule

// File: rtl/codir_rx_dpath.sv
module codir_rx_dpath
  import codir_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      slotA,
  input  logic      slotB,
  input  logic      slotPick,
  input  logic      forceOnes,
  input  rxStrobe_t stb,
  output logic      pcmOut
);
  logic [OCTET_W-1:0] octReg [2];
  logic               wrSel;
  logic               rdSel;
  logic               slotPrev;
  logic [IDX_W-1:0]   rdIdx;
  logic               slotActive, slotStart, readBit;

  always_comb begin
    slotActive = slotPick ? slotA : slotB;
    slotStart  = slotActive & ~slotPrev;
    readBit    = slotStart ? octReg[~wrSel][0] : octReg[rdSel][rdIdx];
  end

  // R3: two octet registers filled in turn, one bit per data strobe
  for (genvar g = 0; g < 2; g++) begin : g_oct
    always_ff @(posedge clk) begin
      if (!rstN) begin
        octReg[g] <= '1;
      end else if (stb.wrEn && (wrSel == 1'(g))) begin
        octReg[g][stb.wrIdx] <= stb.wrBit;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrSel <= 1'b0;
    end else if (stb.commit) begin
      wrSel <= ~wrSel;
    end
  end

  // R3, R5: the newest completed octet is latched at slot start
  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotPrev <= 1'b0;
      rdSel    <= 1'b0;
      rdIdx    <= '0;
    end else begin
      slotPrev <= slotActive;
      if (slotStart) begin
        rdSel <= ~wrSel;
        rdIdx <= IDX_W'(1);
      end else if (slotActive) begin
        rdIdx <= rdIdx + 1'b1;
      end
    end
  end

  // R4, R8, R10: output register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcmOut <= 1'b1;
    end else begin
      pcmOut <= forceOnes | stb.blankHold | ~slotActive | readBit;
    end
  end

  a_r10_force_ones: assert property (@(posedge clk) disable iff (!rstN)
    forceOnes |=> pcmOut);

  a_r4_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    !slotActive |=> pcmOut);

  a_r8_blank_hold: assert property (@(posedge clk) disable iff (!rstN)
    (stb.blankHold && slotActive) |=> pcmOut);

  // R3: during a burst the filling register is never the one being read
  a_r3_no_read_overwrite: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrEn && slotActive && slotPrev) |-> (wrSel != rdSel));
endmodule

// File: rtl/codir_rx_top.sv
module codir_rx_top
  import codir_rx_pkg::*;
#(
  parameter int unsigned MISS_LIMIT = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic railPosN,
  input  logic railNegN,
  input  logic sampleStb,
  input  logic sampleHalf,
  input  logic slotA,
  input  logic slotB,
  input  logic slotPick,
  input  logic flywheelKeep,
  input  logic forceOnes,
  output logic pcmOut,
  output logic octetAlarm
);
  rxStrobe_t stb;

  codir_rx_ctrl #(.MISS_LIMIT(MISS_LIMIT)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .railPosN     (railPosN),
    .railNegN     (railNegN),
    .sampleStb    (sampleStb),
    .sampleHalf   (sampleHalf),
    .flywheelKeep (flywheelKeep),
    .stb          (stb),
    .octetAlarm   (octetAlarm)
  );

  codir_rx_dpath u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .slotA     (slotA),
    .slotB     (slotB),
    .slotPick  (slotPick),
    .forceOnes (forceOnes),
    .stb       (stb),
    .pcmOut    (pcmOut)
  );

  // R11: output idles high and alarm low right after reset
  a_r11_reset_state: assert property (@(posedge clk)
    $past(!rstN) |-> (pcmOut && !octetAlarm));
endmodule

// File: tb/sim_codir_rx_top.sv
module sim_codir_rx_top;
  localparam int CLK_PERIOD = 488;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic railPosN = 1'b1, railNegN = 1'b1, sampleStb = 1'b0, sampleHalf = 1'b0;
  logic slotA = 1'b0, slotB = 1'b0, slotPick = 1'b1, flywheelKeep = 1'b1, forceOnes = 1'b0;
  logic pcmOut, octetAlarm;

  always #(CLK_PERIOD / 2) clk = ~clk;

  codir_rx_top u0 (
    .clk(clk), .rstN(rstN), .railPosN(railPosN), .railNegN(railNegN),
    .sampleStb(sampleStb), .sampleHalf(sampleHalf), .slotA(slotA), .slotB(slotB),
    .slotPick(slotPick), .flywheelKeep(flywheelKeep), .forceOnes(forceOnes),
    .pcmOut(pcmOut), .octetAlarm(octetAlarm)
  );

  int nChecks = 0, nFail = 0;
  bit running = 0;
  bit finished = 0;

  // configuration, applied by the driver at a slot-frame boundary
  bit cfgPick = 1, cfgKeep = 1, cfgForce = 0;
  int cfgPer = 256;
  bit txViolOn = 1;
  int extraBits = 0;
  string phaseTag = "R1";

  // transmitter state
  int cyc = 0, slotCnt = 0, slotPer = 256;
  bit halfNext = 0, havePrevB = 0, prevPolB = 0;
  bit curBit, curViol;
  logic [7:0] txByte;
  int txPos = 0, dirIdx = 0;
  logic [7:0] dirList [4] = '{8'h00, 8'hFF, 8'hA5, 8'h3C};

  // requirement-level model
  int mCnt = 0, mMiss = 0, mSeq = 0, lastSeq = 0;
  bit mLock = 0, mAlarm = 0, mLastValid = 0;
  logic [7:0] mBuf = 8'hFF, mLast = 8'hFF;
  int repeats = 0, drops = 0;

  // slot monitor
  int prevPos = -1, prevUnsel = -1, idleBad = 0;
  logic [7:0] gotByte, expByte;
  bit expValid = 0, expBlank = 0, lastSlotOk = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] nextByte();
    logic [7:0] b;
    if (dirIdx < 4) begin
      b = dirList[dirIdx];
      dirIdx++;
    end else begin
      b = 8'($urandom);
    end
    return b;
  endfunction

  task automatic pickBit();
    if (extraBits > 0) begin
      curBit = 1'b1; curViol = 1'b0; extraBits--;
    end else begin
      curBit  = txByte[txPos];
      curViol = (txPos == 7) && txViolOn;
      txPos++;
      if (txPos == 8) begin
        txPos = 0;
        txByte = nextByte();
      end
    end
  endtask

  task automatic sendHead();
    bit pol;
    pickBit();
    if (!havePrevB) pol = 1'b1;
    else if (curViol) pol = prevPolB;
    else pol = ~prevPolB;
    curViol = curViol && havePrevB;
    prevPolB = pol;
    havePrevB = 1'b1;
    if (pol) railPosN = 1'b0; else railNegN = 1'b0;
  endtask

  task automatic sendData();
    bit lastPos;
    if (!curBit) begin
      if (prevPolB) railPosN = 1'b0; else railNegN = 1'b0;
    end
    mBuf[mCnt] = curBit;
    lastPos = (mCnt == 7);
    if (lastPos) begin
      if (curViol) begin
        mMiss = 0; mLock = 0; mAlarm = 0;
      end else begin
        if (mMiss < 8) mMiss++;
        mLock = 1;
        if (mMiss >= 8) mAlarm = 1;
      end
    end
    if (curViol || lastPos) begin
      mLast = mBuf;
      mLastValid = lastPos;
      mSeq++;
      mCnt = 0;
    end else begin
      mCnt++;
    end
  endtask

  task automatic checkSlot();
    string tg;
    if (expBlank) begin
      tg = forceOnes ? "R10" : "R8";
      check(gotByte == 8'hFF, tg, "blanked burst", gotByte, 8'hFF);
    end else if (expValid) begin
      check(gotByte == expByte, phaseTag, "burst byte", gotByte, expByte);
      lastSlotOk = (gotByte == expByte);
    end
    check(octetAlarm == mAlarm, "R9", "alarm level", octetAlarm, mAlarm);
  endtask

  always @(negedge clk) begin
    if (running) begin
      if (prevPos >= 0) begin
        gotByte[prevPos] = pcmOut;
        if (prevPos == 7) checkSlot();
      end
      if (prevUnsel >= 0) begin
        if (!pcmOut) idleBad++;
        if (prevUnsel == 7) begin
          check(idleBad == 0, "R4", "low bits outside selected slot", idleBad, 0);
          idleBad = 0;
        end
      end
      railPosN = 1'b1; railNegN = 1'b1; sampleStb = 1'b0; sampleHalf = 1'b0;
      if (cyc % 16 == 0) begin
        sampleStb = 1'b1;
        sampleHalf = halfNext;
        if (!halfNext) sendHead(); else sendData();
        halfNext = ~halfNext;
      end
      if (slotCnt == 0) begin
        slotPick = cfgPick; flywheelKeep = cfgKeep; forceOnes = cfgForce; slotPer = cfgPer;
      end
      begin
        bit selHigh, unselHigh;
        selHigh = (slotCnt >= 5) && (slotCnt <= 12);
        unselHigh = (slotCnt >= 133) && (slotCnt <= 140);
        slotA = slotPick ? selHigh : unselHigh;
        slotB = slotPick ? unselHigh : selHigh;
        prevPos = selHigh ? slotCnt - 5 : -1;
        prevUnsel = unselHigh ? slotCnt - 133 : -1;
      end
      if (slotCnt == 5) begin
        expBlank = forceOnes || (mLock && !flywheelKeep);
        expByte = mLast;
        expValid = mLastValid;
        if (mLastValid) begin
          if (mSeq == lastSeq) repeats++;
          if (mSeq - lastSeq >= 2) drops++;
        end
        lastSeq = mSeq;
      end
      slotCnt = (slotCnt + 1 >= slotPer) ? 0 : slotCnt + 1;
      cyc++;
    end
  end

  task automatic runOctets(input int n);
    repeat (n * 256) @(posedge clk);
    #1;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    txByte = nextByte();
    repeat (5) @(posedge clk);
    #1;
    check(pcmOut == 1'b1, "R11", "pcmOut in reset", pcmOut, 1);
    check(octetAlarm == 1'b0, "R11", "alarm in reset", octetAlarm, 0);
    rstN = 1'b1;
    @(posedge clk); #1;
    check(pcmOut == 1'b1 && octetAlarm == 1'b0, "R11", "state after reset", {pcmOut, octetAlarm}, 2);
    running = 1;

    phaseTag = "R1"; runOctets(5);
    phaseTag = "R2"; runOctets(4);
    check(octetAlarm == 1'b0, "R2", "violations recognised, alarm", octetAlarm, 0);

    phaseTag = "R5"; cfgPer = 240; runOctets(16);
    check(repeats > 0, "R5", "repeats seen with fast local frame", repeats, 1);
    cfgPer = 272; runOctets(16);
    check(drops > 0, "R5", "drops seen with slow local frame", drops, 1);
    cfgPer = 256;

    phaseTag = "R4"; cfgPick = 0; runOctets(4);
    cfgPick = 1; runOctets(1);

    phaseTag = "R10"; cfgForce = 1; runOctets(3);
    cfgForce = 0; phaseTag = "R3"; runOctets(3);

    phaseTag = "R7"; extraBits = 3; runOctets(5);
    check(lastSlotOk && expValid, "R7", "aligned data after realignment", lastSlotOk, 1);
    check(octetAlarm == 1'b0, "R7", "alarm after realignment", octetAlarm, 0);

    phaseTag = "R6"; txViolOn = 0; runOctets(7);
    check(octetAlarm == 1'b0, "R9", "alarm before eighth miss", octetAlarm, 0);
    runOctets(3);
    check(octetAlarm == 1'b1, "R9", "alarm after eight misses", octetAlarm, 1);
    check(lastSlotOk, "R6", "flywheel data still valid", lastSlotOk, 1);

    cfgKeep = 0; runOctets(4);
    cfgKeep = 1; txViolOn = 1; runOctets(3);
    check(octetAlarm == 1'b0, "R9", "alarm cleared by violation", octetAlarm, 0);
    check(lastSlotOk, "R6", "data after violations resume", lastSlotOk, 1);

    running = 0;
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end
endmodule